// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

This block gathers eight interrupt inputs that belong to four sub-peripherals and presents them to a host as a byte-wide register file with a 16-bit address. Each sub-peripheral has its own window of configuration and status registers at a fixed base address. In each window every source can be set to edge or level sensing. Two independent polarity bits decide which input state or transition counts. An enable mask is changed through separate write-one-to-set and write-one-to-clear registers. A latched status bit is acknowledged by writing one to it.

Above the windows sits a summary register with one bit per sub-peripheral. A bit is high when that sub-peripheral has a latched source that is also enabled. The single active-high interrupt output is the OR of the summary bits. A handler reads the summary, then reads the latched status of the flagged window, then acknowledges the bits it has served. Inputs are asynchronous and pass through a two-flop synchronizer before any detection.

Input mapping: `src_in[4:0]` are sources 0 to 4 of sub-peripheral 0; `src_in[5]`, `src_in[6]` and `src_in[7]` are source 0 of sub-peripherals 1, 2 and 3.

Top module: `hier_irq_ctrl`

## Requirements
- R1: Windows start at 0x0900, 0x2400, 0xC000 and 0xC100 for sub-peripherals 0 to 3. The register offsets within a window are: raw level 0x10, type 0x11, high polarity 0x12, low polarity 0x13, acknowledge 0x14, enable-set 0x15, enable-clear 0x16 and latched status 0x18. The summary is at 0x0550. Every other address, and the acknowledge offset, reads 0x00.
- R2: The raw-level register returns each input after a two-flop synchronizer, so it follows a change in the input two rising clock edges later.
- R3: With type bit 1 (edge), a 0-to-1 change latches the source if its high-polarity bit is 1 and a 1-to-0 change latches it if its low-polarity bit is 1. The latched bit is visible one edge after the raw level changes.
- R4: With type bit 0 (level), the source latches while the synchronized input is 1 and high polarity is set, or while it is 0 and low polarity is set. An acknowledge does not clear it while that condition holds.
- R5: Writing 1 to a bit of enable-set sets that enable bit, and writing 1 to enable-clear clears it. Zero bits written change nothing, and both offsets read back the enable mask.
- R6: Writing 1 to a bit at the acknowledge offset clears that latched bit of an edge-mode source. Latching is independent of the enable, and a latched bit changes to 0 only on a register write.
- R7: Summary bit n is 1 exactly when sub-peripheral n has some bit that is both latched and enabled.
- R8: `irq_out` is high exactly when at least one summary bit is 1.
- R9: Sub-peripheral 0 uses bits 0 to 4 and the others use bit 0 only. Unused bits ignore writes and read 0.
- R10: After reset all type, polarity, enable and latched bits are 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 8 | Asynchronous interrupt inputs |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Write strobe, acted on at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
The bench sweeps every source through all eight combinations of type and the two polarity bits. For each combination it raises the input, acknowledges, and lowers the input, which exposes the following faults. A design that swapped the polarity bits would latch on the wrong transition. A design that let an acknowledge win over an active level would drop a live level interrupt. A design that gated latching with the enable would lose the pending state. Enable-set and enable-clear are written with zero bits and with bits outside the used range, which catches decode that does a full write or leaks into unused bits. One exact-cycle check pins the synchronizer and latch delays, so an extra or missing register stage fails.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int NPER  = 4;
  localparam int NSRC  = 8;
  localparam int OFFW  = 5;

  localparam logic [OFFW-1:0] OFF_RAW  = 5'h10;
  localparam logic [OFFW-1:0] OFF_TYPE = 5'h11;
  localparam logic [OFFW-1:0] OFF_PHI  = 5'h12;
  localparam logic [OFFW-1:0] OFF_PLO  = 5'h13;
  localparam logic [OFFW-1:0] OFF_ACK  = 5'h14;
  localparam logic [OFFW-1:0] OFF_ENS  = 5'h15;
  localparam logic [OFFW-1:0] OFF_ENC  = 5'h16;
  localparam logic [OFFW-1:0] OFF_LAT  = 5'h18;

  localparam logic [AW-1:0] SUMMARY_ADDR = 16'h0550;

  function automatic logic [AW-1:0] per_base(input int idx);
    case (idx)
      0:       per_base = 16'h0900;
      1:       per_base = 16'h2400;
      2:       per_base = 16'hC000;
      default: per_base = 16'hC100;
    endcase
  endfunction

  function automatic int per_nsrc(input int idx);
    per_nsrc = (idx == 0) ? 5 : 1;
  endfunction

  function automatic int per_lsb(input int idx);
    per_lsb = (idx == 0) ? 0 : 4 + idx;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] is_edge,
  input  logic [N-1:0] pol_hi,
  input  logic [N-1:0] pol_lo,
  output logic [N-1:0] fire
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise, fall, edge_fire, lvl_fire;

  always_comb begin
    rise      = lvl & ~prev_q;
    fall      = ~lvl & prev_q;
    edge_fire = (pol_hi & rise) | (pol_lo & fall);
    lvl_fire  = (pol_hi & lvl) | (pol_lo & ~lvl);
    fire      = (is_edge & edge_fire) | (~is_edge & lvl_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end
endmodule

// File: rtl/irqc_periph.sv
module irqc_periph
  import irqc_pkg::*;
#(
  parameter int          N    = 1,
  parameter logic [15:0] BASE = 16'h0900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lvl,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pending,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  lat_o
);
  logic [AW-1:0]   rel;
  logic            hit;
  logic [OFFW-1:0] off;
  logic [N-1:0]    wbits;

  logic [N-1:0] typ_q, phi_q, plo_q, en_q, lat_q;
  logic [N-1:0] typ_d, phi_d, plo_d, en_d, lat_d;
  logic [N-1:0] fire;
  logic         we_type, we_phi, we_plo, we_ack, we_ens, we_enc;

  assign rel   = addr - BASE;
  assign hit   = (rel[AW-1:OFFW] == '0);
  assign off   = rel[OFFW-1:0];
  assign wbits = wdata[N-1:0];

  assign we_type = wr && hit && (off == OFF_TYPE);
  assign we_phi  = wr && hit && (off == OFF_PHI);
  assign we_plo  = wr && hit && (off == OFF_PLO);
  assign we_ack  = wr && hit && (off == OFF_ACK);
  assign we_ens  = wr && hit && (off == OFF_ENS);
  assign we_enc  = wr && hit && (off == OFF_ENC);

  irqc_detect #(.N(N)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .is_edge (typ_q),
    .pol_hi  (phi_q),
    .pol_lo  (plo_q),
    .fire    (fire)
  );

  always_comb begin
    typ_d = typ_q;
    phi_d = phi_q;
    plo_d = plo_q;
    en_d  = en_q;
    if (we_type) typ_d = wbits;
    if (we_phi)  phi_d = wbits;
    if (we_plo)  plo_d = wbits;
    if (we_ens)  en_d  = en_q | wbits;
    if (we_enc)  en_d  = en_q & ~wbits;
    lat_d = we_ack ? (lat_q & ~wbits) : lat_q;
    lat_d = lat_d | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= '0;
      phi_q <= '0;
      plo_q <= '0;
      en_q  <= '0;
      lat_q <= '0;
    end else begin
      typ_q <= typ_d;
      phi_q <= phi_d;
      plo_q <= plo_d;
      en_q  <= en_d;
      lat_q <= lat_d;
    end
  end

  function automatic logic [DW-1:0] widen(input logic [N-1:0] v);
    logic [DW-1:0] t;
    t        = '0;
    t[N-1:0] = v;
    return t;
  endfunction

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (off)
        OFF_RAW:         rdata = widen(lvl);
        OFF_TYPE:        rdata = widen(typ_q);
        OFF_PHI:         rdata = widen(phi_q);
        OFF_PLO:         rdata = widen(plo_q);
        OFF_ENS, OFF_ENC: rdata = widen(en_q);
        OFF_LAT:         rdata = widen(lat_q);
        default:         rdata = '0;
      endcase
    end
  end

  assign pending = |(lat_q & en_q);
  assign en_o    = en_q;
  assign lat_o   = lat_q;
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    src_in,
  input  logic [15:0]   reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_out
);
  logic [NSRC-1:0] sync_lvl;
  logic [NSRC-1:0] en_all;
  logic [NSRC-1:0] lat_all;
  logic [NPER-1:0] summary;
  logic [DW-1:0]   per_rd [NPER];

  irqc_sync #(.W(NSRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (src_in),
    .sync_out (sync_lvl)
  );

  for (genvar p = 0; p < NPER; p++) begin : g_per
    localparam int          NS = per_nsrc(p);
    localparam int          LO = per_lsb(p);
    localparam logic [15:0] BA = per_base(p);

    irqc_periph #(.N(NS), .BASE(BA)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (sync_lvl[LO +: NS]),
      .addr    (reg_addr),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rdata   (per_rd[p]),
      .pending (summary[p]),
      .en_o    (en_all[LO +: NS]),
      .lat_o   (lat_all[LO +: NS])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SUMMARY_ADDR) reg_rdata = DW'(summary);
    for (int p = 0; p < NPER; p++) reg_rdata = reg_rdata | per_rd[p];
  end

  assign irq_out = |summary;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    src_in,
  input logic [15:0]   reg_addr,
  input logic          reg_wr,
  input logic [7:0]    reg_rdata,
  input logic          irq_out,
  input logic [NSRC-1:0] sync_lvl,
  input logic [NSRC-1:0] en_all,
  input logic [NSRC-1:0] lat_all
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (sync_lvl == $past(src_in, 2)));

  p_en_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_all));

  p_lat_no_spont_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((lat_all & $past(lat_all)) == $past(lat_all)));

  p_summary_vs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(en_all & lat_all)));

  p_irq_from_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SUMMARY_ADDR) |-> (irq_out == (reg_rdata != 8'h00)));

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[15:12] == 4'h1) |-> (reg_rdata == 8'h00));

  p_unused_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[15:5] == 11'h120) |-> (reg_rdata[7:1] == 7'h00));
endmodule

bind hier_irq_ctrl irqc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_in    (src_in),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .sync_lvl  (sync_lvl),
  .en_all    (en_all),
  .lat_all   (lat_all)
);

// File: tb/sim_hier_irq_ctrl.sv
module sim_hier_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_in = '0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] base_of(int p);
    case (p)
      0: return 16'h0900;
      1: return 16'h2400;
      2: return 16'hC000;
      default: return 16'hC100;
    endcase
  endfunction
  function automatic int nsrc_of(int p); return (p == 0) ? 5 : 1; endfunction
  function automatic int lsb_of(int p);  return (p == 0) ? 0 : 4 + p; endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_sum(string req, int p, logic [7:0] lat, bit en);
    logic [7:0] v;
    logic [7:0] es;
    es = (en && lat != 0) ? 8'(1 << p) : 8'h00;
    rd(16'h0550, v);
    check({req, " summary"}, v, es);
    check({req, " irq_out"}, {7'b0, irq_out}, {7'b0, es != 0});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state of all windows
    for (int p = 0; p < 4; p++) begin
      rd(base_of(p) + 16'h11, v); check("R10 type", v, 8'h00);
      rd(base_of(p) + 16'h12, v); check("R10 pol_hi", v, 8'h00);
      rd(base_of(p) + 16'h13, v); check("R10 pol_lo", v, 8'h00);
      rd(base_of(p) + 16'h15, v); check("R10 enable", v, 8'h00);
      rd(base_of(p) + 16'h18, v); check("R10 latched", v, 8'h00);
    end
    check("R10 irq_out", {7'b0, irq_out}, 8'h00);

    // R1: unmapped addresses and acknowledge offset read zero
    rd(16'h0000, v); check("R1 unmapped 0000", v, 8'h00);
    rd(16'h1234, v); check("R1 unmapped 1234", v, 8'h00);
    rd(16'h0917, v); check("R1 hole 0x17", v, 8'h00);
    wr(16'h0911, 8'h1F);
    rd(16'h0914, v); check("R1 ack reads 0", v, 8'h00);
    rd(16'h0911, v); check("R1 type readback", v, 8'h1F);
    wr(16'h0911, 8'h00);

    // R9: unused bits ignore writes
    for (int p = 0; p < 4; p++) begin
      logic [7:0] m;
      m = 8'((1 << nsrc_of(p)) - 1);
      wr(base_of(p) + 16'h12, 8'hFF);
      rd(base_of(p) + 16'h12, v); check("R9 pol_hi width", v, m);
      wr(base_of(p) + 16'h12, 8'h00);
    end

    // R5: set/clear semantics, zero bits no effect, both offsets read mask
    wr(16'h0915, 8'h05);
    wr(16'h0915, 8'h00);
    rd(16'h0915, v); check("R5 set zero no effect", v, 8'h05);
    wr(16'h0915, 8'h0A);
    rd(16'h0916, v); check("R5 set accumulates", v, 8'h0F);
    wr(16'h0916, 8'h00);
    rd(16'h0916, v); check("R5 clear zero no effect", v, 8'h0F);
    wr(16'h0916, 8'h03);
    rd(16'h0915, v); check("R5 clear bits", v, 8'h0C);
    wr(16'h0916, 8'hFF);
    rd(16'h0915, v); check("R5 clear all", v, 8'h00);

    // R2/R3: exact latency for an edge on peripheral 2
    wr(16'hC011, 8'h01);
    wr(16'hC012, 8'h01);
    @(negedge clk);
    src_in[6] = 1'b1;
    @(negedge clk);
    rd(16'hC010, v); check("R2 raw after one edge", v, 8'h00);
    @(negedge clk);
    rd(16'hC010, v); check("R2 raw after two edges", v, 8'h01);
    rd(16'hC018, v); check("R3 latch not yet", v, 8'h00);
    @(negedge clk);
    rd(16'hC018, v); check("R3 latch after three edges", v, 8'h01);
    src_in[6] = 1'b0;
    repeat (4) @(negedge clk);
    wr(16'hC011, 8'h00); wr(16'hC012, 8'h00); wr(16'hC014, 8'hFF);
    rd(16'hC018, v); check("R6 ack clears", v, 8'h00);

    // Sweep: every source, every type/polarity combination
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < nsrc_of(p); b++) begin
        for (int cfg = 0; cfg < 8; cfg++) begin
          bit ty, ph, pl, en;
          int g;
          logic [7:0] bm, exp;
          logic [15:0] ba;
          ty = cfg[0]; ph = cfg[1]; pl = cfg[2];
          g  = lsb_of(p) + b;
          en = ((g + cfg) % 2) == 0;
          bm = 8'(1 << b);
          ba = base_of(p);
          wr(ba + 16'h11, ty ? bm : 8'h00);
          wr(ba + 16'h12, ph ? bm : 8'h00);
          wr(ba + 16'h13, pl ? bm : 8'h00);
          wr(ba + 16'h16, 8'hFF);
          if (en) wr(ba + 16'h15, bm);
          wr(ba + 16'h14, 8'hFF);
          // input low: only level-low is active (R4)
          exp = (!ty && pl) ? bm : 8'h00;
          rd(ba + 16'h18, v); check("R4 idle low after ack", v, exp);
          check_sum("R7", p, exp, en);
          // raise input
          src_in[g] = 1'b1;
          repeat (4) @(negedge clk);
          rd(ba + 16'h10, v); check("R2 raw high", v, bm);
          if (ph) exp = exp | bm;
          rd(ba + 16'h18, v); check(ty ? "R3 rising" : "R4 level high", v, exp);
          check_sum("R8", p, exp, en);
          // acknowledge: level-high still active keeps the bit (R4), edge clears (R6)
          wr(ba + 16'h14, bm);
          exp = (!ty && ph) ? bm : 8'h00;
          rd(ba + 16'h18, v); check(ty ? "R6 ack edge" : "R4 ack while active", v, exp);
          // lower input
          src_in[g] = 1'b0;
          repeat (4) @(negedge clk);
          if (pl) exp = exp | bm;
          rd(ba + 16'h18, v); check(ty ? "R3 falling" : "R4 level low", v, exp);
          check_sum("R7", p, exp, en);
          // cleanup
          wr(ba + 16'h11, 8'h00); wr(ba + 16'h12, 8'h00); wr(ba + 16'h13, 8'h00);
          wr(ba + 16'h16, 8'hFF); wr(ba + 16'h14, 8'hFF);
        end
      end
    end

    check("R8 idle irq_out", {7'b0, irq_out}, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule